// File: doc/BRIEF.md
# Programmable Scan Trigger Generator

This block issues scan-start pulses to a multichannel acquisition engine. A 4-bit rate code chooses the trigger source. Seven codes select fixed internal scan rates from 100,000 down to 10 scans per second. These rates come from a prescaler that divides the system clock into a base tick of 10 µs. One code hands triggering to an external hardware line and to a software strobe. All remaining codes block triggering completely.

Nothing triggers while the arm input is low. The external line is asynchronous, so it is synchronised before use, and only its rising edge counts. Each accepted trigger produces a single-cycle `scanStart` pulse. It also restarts a stretch counter, which holds `trigActive` high for long enough to drive a front-panel lamp.

The internal rate timer restarts whenever the rate code changes or arm is low. The first internal trigger therefore arrives exactly one full period after arming or after a rate change.

Top module: `scanTrigGen`

## Requirements
- R1: For rate codes 1 to 7 with arm held high, `scanStart` pulses once every P×TICK_DIV clock cycles. P is the period in 10 µs base ticks: 1, 5, 20, 100, 500, 2000 and 10000 for codes 1 to 7 in that order.
- R2: With rate code 0 and arm high, a rising edge on `extTrigAsync` produces one `scanStart` pulse. The input is first registered by two synchroniser flops, so a level that is high at clock edge k gives a pulse visible after edge k+2. A level held high gives no further pulses, and code 0 produces no internal triggers.
- R3: Rate code 15 produces no `scanStart`, whatever `softTrig`, `extTrigAsync` and arm do.
- R4: With rate code 0 and arm high, `softTrig` high at a clock edge produces `scanStart` after that edge. `softTrig` has no effect under any other code.
- R5: While arm is low, `scanStart` stays low under every code.
- R6: Rate codes 8 to 14 behave exactly like code 15.
- R7: The rate timer restarts whenever arm is low or the rate code differs from its value at the previous edge. The first internal pulse comes P×TICK_DIV cycles after the first edge on which arm is high and the code is unchanged.
- R8: `trigActive` goes high in the same cycle as each `scanStart` and stays high for STRETCH cycles. A new trigger during that window restarts the full STRETCH count.
- R9: During and right after reset, `scanStart` and `trigActive` are low.
- R10: With an internal rate code and TICK_DIV of at least 2, `scanStart` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateCode | input | 4 | Rate or trigger source code |
| arm | input | 1 | Allows triggers while high |
| softTrig | input | 1 | Software trigger strobe, synchronous to clk |
| extTrigAsync | input | 1 | External hardware trigger, asynchronous |
| scanStart | output | 1 | One-cycle scan-start pulse |
| trigActive | output | 1 | Trigger activity, stretched for a lamp |

## Verification
The assertions assume that `rateCode`, `arm` and `softTrig` are synchronous to `clk` and stable around each rising edge. The single-cycle check assumes TICK_DIV is at least 2. The bench drives every input only on falling edges, so all inputs, including the external line, meet that assumption. It runs the prescaler with TICK_DIV of 2, which keeps even the 10-scan-per-second period to 20,000 cycles while keeping the tick divider in use.

// File: rtl/scan_trig_pkg.sv
package scan_trig_pkg;

  localparam logic [3:0] CODE_EXT = 4'd0;
  localparam logic [3:0] CODE_OFF = 4'd15;
  localparam int PER_W = 14;

  // Strobes from control to datapath
  typedef struct packed {
    logic       restart;   // clear the rate timer
    logic       intEn;     // internal rate selected and armed
    logic       extEn;     // external/soft source selected and armed
    logic [2:0] rateSel;   // index of the internal rate, 0 = fastest
  } trigCtl_t;

  // Period in 10 us base ticks for each internal rate
  function automatic logic [PER_W-1:0] ratePeriod(input logic [2:0] sel);
    case (sel)
      3'd0:    ratePeriod = PER_W'(1);
      3'd1:    ratePeriod = PER_W'(5);
      3'd2:    ratePeriod = PER_W'(20);
      3'd3:    ratePeriod = PER_W'(100);
      3'd4:    ratePeriod = PER_W'(500);
      3'd5:    ratePeriod = PER_W'(2000);
      3'd6:    ratePeriod = PER_W'(10000);
      default: ratePeriod = PER_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/scanTrigCtrl.sv
module scanTrigCtrl
  import scan_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] rateCode,
  input  logic       arm,
  output trigCtl_t   ctl
);

  logic [3:0] codeQ;
  logic [3:0] selW;
  logic       isInternal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) codeQ <= CODE_OFF;
    else       codeQ <= rateCode;
  end

  always_comb begin
    isInternal  = (rateCode >= 4'd1) && (rateCode <= 4'd7);
    selW        = rateCode - 4'd1;
    ctl.restart = !arm || (rateCode != codeQ);
    ctl.intEn   = arm && isInternal;
    ctl.extEn   = arm && (rateCode == CODE_EXT);
    ctl.rateSel = selW[2:0];
  end

endmodule

// File: rtl/scanTrigDp.sv
module scanTrigDp
  import scan_trig_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int STRETCH     = 2000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  trigCtl_t ctl,
  input  logic     softTrig,
  input  logic     extTrigAsync,
  output logic     scanStart,
  output logic     trigActive
);

  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int STR_W  = $clog2(STRETCH + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

  logic [SYNC_STAGES:0] extSh;
  logic [TICK_W-1:0]    tickCnt;
  logic [PER_W-1:0]     perCnt;
  logic [PER_W-1:0]     perLast;
  logic [STR_W-1:0]     strCnt;
  logic                 tick, extRise, intFire, extFire, anyFire;

  // synchroniser plus one edge-detect stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSh <= '0;
    else       extSh <= {extSh[SYNC_STAGES-1:0], extTrigAsync};
  end

  always_comb begin
    extRise = extSh[SYNC_STAGES-1] & ~extSh[SYNC_STAGES];
    tick    = (tickCnt == TICK_LAST);
    perLast = ratePeriod(ctl.rateSel) - PER_W'(1);
    intFire = ctl.intEn && !ctl.restart && tick && (perCnt == perLast);
    extFire = ctl.extEn && (extRise || softTrig);
    anyFire = intFire || extFire;
  end

  // prescaler and period timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      perCnt  <= '0;
    end else if (ctl.restart || !ctl.intEn) begin
      tickCnt <= '0;
      perCnt  <= '0;
    end else begin
      tickCnt <= tick ? '0 : tickCnt + TICK_W'(1);
      if (tick) perCnt <= (perCnt == perLast) ? '0 : perCnt + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanStart <= 1'b0;
      strCnt    <= '0;
    end else begin
      scanStart <= anyFire;
      if (anyFire)          strCnt <= STR_W'(STRETCH);
      else if (strCnt != 0) strCnt <= strCnt - STR_W'(1);
    end
  end

  assign trigActive = (strCnt != '0);

endmodule

// File: rtl/scanTrigGen.sv
module scanTrigGen
  import scan_trig_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int STRETCH  = 2000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] rateCode,
  input  logic       arm,
  input  logic       softTrig,
  input  logic       extTrigAsync,
  output logic       scanStart,
  output logic       trigActive
);

  trigCtl_t ctl;

  scanTrigCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rateCode (rateCode),
    .arm      (arm),
    .ctl      (ctl)
  );

  scanTrigDp #(
    .TICK_DIV    (TICK_DIV),
    .STRETCH     (STRETCH),
    .SYNC_STAGES (2)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .softTrig     (softTrig),
    .extTrigAsync (extTrigAsync),
    .scanStart    (scanStart),
    .trigActive   (trigActive)
  );

endmodule

// File: rtl/scanTrigGen_chk.sv
module scanTrigGen_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] rateCode,
  input logic       arm,
  input logic       softTrig,
  input logic       scanStart,
  input logic       trigActive
);

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == 4'd15) |=> !scanStart);

  p_high_codes_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode >= 4'd8) |=> !scanStart);

  p_unarmed_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !arm |=> !scanStart);

  p_soft_fires_r4: assert property (@(posedge clk) disable iff (!rstN)
    (arm && rateCode == 4'd0 && softTrig) |=> scanStart);

  p_lamp_with_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    scanStart |-> trigActive);

  p_arm_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(arm) && rateCode != 4'd0) |=> !scanStart);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (scanStart && $stable(rateCode) && rateCode >= 4'd1 && rateCode <= 4'd7)
      |=> !scanStart);

endmodule

bind scanTrigGen scanTrigGen_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .rateCode   (rateCode),
  .arm        (arm),
  .softTrig   (softTrig),
  .scanStart  (scanStart),
  .trigActive (trigActive)
);

// File: tb/scanTrigGen_tb_top.sv
module scanTrigGen_tb_top;

  localparam int TD = 2;
  localparam int ST = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] rateCode = 4'd15;
  logic       arm = 1'b0;
  logic       softTrig = 1'b0;
  logic       extTrig = 1'b0;
  logic       scanStart, trigActive;

  always #2 clk = ~clk;  // 250 MHz

  scanTrigGen #(.TICK_DIV(TD), .STRETCH(ST)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .rateCode     (rateCode),
    .arm          (arm),
    .softTrig     (softTrig),
    .extTrigAsync (extTrig),
    .scanStart    (scanStart),
    .trigActive   (trigActive)
  );

  // behavioural reference
  int         elapsed, act, per, nVec, nBad;
  logic [3:0] prevCode;
  bit         hist[$];
  bit         expStart, restart, fire, rise, running;
  string      curReq = "R9";

  function automatic int perOf(logic [3:0] c);
    case (c)
      4'd1: return 1 * TD;
      4'd2: return 5 * TD;
      4'd3: return 20 * TD;
      4'd4: return 100 * TD;
      4'd5: return 500 * TD;
      4'd6: return 2000 * TD;
      4'd7: return 10000 * TD;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      elapsed = 0; act = 0; expStart = 0; prevCode = 4'd15;
      hist = '{0, 0, 0};
    end else begin
      restart  = !arm || (rateCode != prevCode);
      prevCode = rateCode;
      per      = perOf(rateCode);
      fire     = 0;
      if (restart || per == 0) elapsed = 0;
      else begin
        elapsed++;
        fire = (elapsed % per) == 0;
      end
      // hist[0] newest sample; edge seen between 2nd and 3rd stored samples
      rise = hist[1] && !hist[2];
      hist.push_front(extTrig);
      void'(hist.pop_back());
      expStart = fire || (arm && rateCode == 4'd0 && (rise || softTrig));
      if (expStart) act = ST;
      else if (act > 0) act--;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      nVec++;
      if (scanStart !== expStart) begin
        nBad++;
        $display("FAIL %s scanStart actual=%b expected=%b t=%0t", curReq, scanStart, expStart, $time);
      end
      if (trigActive !== (act > 0)) begin
        nBad++;
        $display("FAIL %s trigActive actual=%b expected=%b t=%0t", curReq, trigActive, act > 0, $time);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL %s watchdog actual=running expected=finished", curReq);
    summary();
  end

  initial begin
    hist = '{0, 0, 0};
    running = 1;
    // R9: reset state
    curReq = "R9";
    run(4);
    rstN = 1'b1;
    run(3);
    // R1 / R7 / R10: fastest rate, then period of 20 ticks
    curReq = "R1";
    rateCode = 4'd1; arm = 1'b1; run(30);
    curReq = "R10"; run(10);
    curReq = "R1";
    rateCode = 4'd3; run(130);
    rateCode = 4'd2; run(50);
    // R7: code change and re-arm restart the timer
    curReq = "R7";
    run(7); rateCode = 4'd4; run(230);
    arm = 1'b0; run(3); arm = 1'b1; run(210);
    // R1: slowest rate, 20000 cycles
    curReq = "R1";
    rateCode = 4'd7; run(20050);
    rateCode = 4'd5; run(1010);
    rateCode = 4'd6; run(30);
    // R5: unarmed under several codes
    curReq = "R5";
    arm = 1'b0; rateCode = 4'd1; run(20);
    rateCode = 4'd0; softTrig = 1'b1; run(2); softTrig = 1'b0;
    extTrig = 1'b1; run(4); extTrig = 1'b0; run(12);
    // R2: external edge, held level, short pulse
    curReq = "R2";
    arm = 1'b1; run(12);
    extTrig = 1'b1; run(30); extTrig = 1'b0; run(15);
    extTrig = 1'b1; run(1); extTrig = 1'b0; run(15);
    // R4: soft strobe, R8 retrigger inside stretch
    curReq = "R4";
    softTrig = 1'b1; run(1); softTrig = 1'b0; run(15);
    curReq = "R8";
    softTrig = 1'b1; run(1); softTrig = 1'b0; run(4);
    softTrig = 1'b1; run(1); softTrig = 1'b0; run(15);
    // R4: soft ignored under internal code
    curReq = "R4";
    rateCode = 4'd2; run(3); softTrig = 1'b1; run(1); softTrig = 1'b0; run(20);
    // R3: disabled code ignores everything
    curReq = "R3";
    rateCode = 4'd15; run(5);
    softTrig = 1'b1; extTrig = 1'b1; run(3); softTrig = 1'b0; extTrig = 1'b0; run(20);
    // R6: codes 8 to 14 behave as disabled
    curReq = "R6";
    for (int c = 8; c <= 14; c++) begin
      rateCode = 4'(c);
      softTrig = 1'b1; extTrig = 1'b1; run(2);
      softTrig = 1'b0; extTrig = 1'b0; run(30);
    end
    run(5);
    running = 0;
    summary();
  end

endmodule